// File: doc/BRIEF.md
# Exception Priority and Vectoring Unit

This unit sits at the retirement end of a processor pipeline. When an instruction-boundary strobe is high, it looks at every event request present at that boundary and picks the single most urgent one. The candidates are asynchronous system events (hardware reset request, machine check, INIT, system management), a trap or software interrupt raised by the instruction that just retired, external interrupts (non-maskable and maskable), and faults reported against the instruction at the boundary. For the chosen event it pulses a take strobe and a pipeline flush. In the same cycle it presents an 8-bit vector number and the return PC for the handler.

The return PC depends on the kind of event. A fault returns to the faulting instruction so that it runs again. A trap, a software interrupt or an external event returns to the next instruction, which is the jump target when the retired instruction was a taken jump. Reset and machine check cannot be restarted and report zero. Once an event is taken, the unit clears its interrupt-enable flag and ignores boundaries until a return-from-interrupt pulse arrives. That pulse restores the flag. Asynchronous events are held pending until they are serviced. Synchronous requests are expected to be raised again by the pipeline when the faulting code runs again.

Top module: `exc_vector_unit`

## Requirements
- R1: After reset, take_o, flush_o and busy_o are 0 and ie_o equals the IE_RST parameter (default 1).
- R2: Requests are sampled only on a rising edge where boundary_i is 1 and busy_o is 0. take_o rises in the cycle after that edge and stays high for exactly one cycle.
- R3: Priority, highest first, by internal class index 0..12: hardware reset request, machine check, INIT, SMI, trap, software interrupt, NMI, maskable interrupt, data-TLB fault, FP fault, alignment fault, instruction-TLB fault, illegal opcode.
- R4: Vectors (hex) by class: reset 01, machine check 12, INIT 03, SMI 04, trap 05, NMI 02, maskable 20, data-TLB 0E, FP 10, alignment 11, instruction-TLB 0F, illegal opcode 06. A software interrupt outputs swi_vec_i unchanged.
- R5: ret_pc_o is fault_pc_i for the five fault classes. It is zero for reset and machine check. For every other class it is jump_tgt_i when jump_taken_i is 1, and seq_pc_i otherwise.
- R6: intr_i is taken only while ie_o is 1. NMI and software interrupts are taken whatever the value of ie_o.
- R7: Taking an event sets busy_o to 1 and ie_o to 0. While busy, boundaries are ignored. An iret_i pulse clears busy_o and restores ie_o to its value just before the take.
- R8: Pulses on hw_reset_req_i, mcheck_i, init_i, smi_i and nmi_i are captured on any edge, including while busy or with no boundary. Each stays pending until its class is taken.
- R9: Trap, software interrupt, fault and maskable requests are not held. If one is not selected at its boundary, it has no effect afterwards.
- R10: ie_wr_i on an idle edge loads ie_val_i into ie_o. While busy the write is ignored.
- R11: flush_o is high in exactly the cycles where take_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boundary_i | input | 1 | Instruction-boundary strobe |
| fault_pc_i | input | PC_W | PC of the instruction at the boundary |
| seq_pc_i | input | PC_W | Sequential successor of the retired instruction |
| jump_taken_i | input | 1 | Retired instruction was a taken jump |
| jump_tgt_i | input | PC_W | Target of that jump |
| hw_reset_req_i | input | 1 | Hardware reset request pulse |
| mcheck_i | input | 1 | Machine check pulse |
| init_i | input | 1 | INIT pulse |
| smi_i | input | 1 | System management interrupt pulse |
| trap_i | input | 1 | Trap from the retired instruction |
| swi_i | input | 1 | Software interrupt from the retired instruction |
| swi_vec_i | input | 8 | Operand vector of the software interrupt |
| nmi_i | input | 1 | Non-maskable interrupt pulse |
| intr_i | input | 1 | Maskable interrupt level |
| dtlb_fault_i | input | 1 | Data TLB fault |
| fpe_fault_i | input | 1 | Floating-point fault |
| align_fault_i | input | 1 | Alignment fault |
| itlb_fault_i | input | 1 | Instruction TLB fault |
| illop_fault_i | input | 1 | Illegal opcode fault |
| iret_i | input | 1 | Return-from-interrupt pulse |
| ie_wr_i | input | 1 | Interrupt-enable write strobe |
| ie_val_i | input | 1 | Interrupt-enable write value |
| take_o | output | 1 | Event taken (one cycle) |
| flush_o | output | 1 | Flush younger instructions |
| vector_o | output | 8 | Selected vector number |
| ret_pc_o | output | PC_W | Saved return PC |
| busy_o | output | 1 | Handler in progress |
| ie_o | output | 1 | Interrupt-enable flag |

## Verification
The properties rely on a few input conventions. iret_i is only pulsed while a handler is in progress. A maskable take can only be told apart from a software interrupt carrying the same number by looking at swi_i at the sampling edge, so the masking property excludes that case. The bench drives every request for one cycle and raises iret_i only after a take it has observed. It writes the enable flag only at points where it has checked the outcome at the ports. It never pulses a latched event on the same edge that would take that class, so every expected take follows from the ladder and from the pending state the bench tracks itself.

// File: rtl/exc_pkg.sv
package exc_pkg;

    localparam int NCLS  = 13;
    localparam int VEC_W = 8;

    typedef enum logic [3:0] {
        C_HWRST = 4'd0,
        C_MCHK  = 4'd1,
        C_INIT  = 4'd2,
        C_SMI   = 4'd3,
        C_TRAP  = 4'd4,
        C_SWI   = 4'd5,
        C_NMI   = 4'd6,
        C_INTR  = 4'd7,
        C_DTLB  = 4'd8,
        C_FPE   = 4'd9,
        C_ALIGN = 4'd10,
        C_ITLB  = 4'd11,
        C_ILLOP = 4'd12
    } exc_cls_e;

    typedef enum logic [1:0] {
        RK_ZERO  = 2'd0,
        RK_FAULT = 2'd1,
        RK_NEXT  = 2'd2
    } ret_kind_e;

    // Classes whose request pulses are held until serviced
    localparam logic [NCLS-1:0] STICKY_MASK =
        (NCLS'(1) << C_HWRST) | (NCLS'(1) << C_MCHK) | (NCLS'(1) << C_INIT) |
        (NCLS'(1) << C_SMI)   | (NCLS'(1) << C_NMI);

    function automatic logic [VEC_W-1:0] fixed_vec(input exc_cls_e c);
        logic [VEC_W-1:0] v;
        case (c)
            C_HWRST: v = 8'h01;
            C_MCHK:  v = 8'h12;
            C_INIT:  v = 8'h03;
            C_SMI:   v = 8'h04;
            C_TRAP:  v = 8'h05;
            C_NMI:   v = 8'h02;
            C_INTR:  v = 8'h20;
            C_DTLB:  v = 8'h0E;
            C_FPE:   v = 8'h10;
            C_ALIGN: v = 8'h11;
            C_ITLB:  v = 8'h0F;
            C_ILLOP: v = 8'h06;
            default: v = '0;
        endcase
        return v;
    endfunction

    function automatic ret_kind_e ret_kind(input exc_cls_e c);
        ret_kind_e k;
        case (c)
            C_HWRST, C_MCHK:                          k = RK_ZERO;
            C_DTLB, C_FPE, C_ALIGN, C_ITLB, C_ILLOP:  k = RK_FAULT;
            default:                                  k = RK_NEXT;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/exc_pend_latch.sv
module exc_pend_latch #(
    parameter int              N    = 13,
    parameter logic [N-1:0]    MASK = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] raw_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] eff_o
);

    for (genvar i = 0; i < N; i++) begin : g_bit
        if (MASK[i]) begin : g_sticky
            logic held_q;
            always_ff @(posedge clk) begin
                if (rst) held_q <= 1'b0;
                else     held_q <= (held_q | raw_i[i]) & ~clr_i[i];
            end
            assign eff_o[i] = held_q | raw_i[i];
        end else begin : g_live
            assign eff_o[i] = raw_i[i];
        end
    end

endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter #(
    parameter int N  = 13,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  req_i,
    output logic [N-1:0]  grant_o,
    output logic [IW-1:0] idx_o,
    output logic          any_o
);

    logic [N:0] seen;
    assign seen[0] = 1'b0;

    // index 0 has the highest priority
    for (genvar i = 0; i < N; i++) begin : g_chain
        assign grant_o[i]  = req_i[i] & ~seen[i];
        assign seen[i+1]   = seen[i] | req_i[i];
    end

    assign any_o = seen[N];

    always_comb begin
        idx_o = '0;
        for (int k = 0; k < N; k++) begin
            if (grant_o[k]) idx_o = IW'(k);
        end
    end

endmodule

// File: rtl/exc_ctrl.sv
module exc_ctrl #(
    parameter logic IE_RST = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic boundary_i,
    input  logic any_req_i,
    input  logic iret_i,
    input  logic ie_wr_i,
    input  logic ie_val_i,
    output logic take_now_o,
    output logic busy_o,
    output logic ie_o
);

    logic busy_q, ie_q, ie_save_q;

    assign take_now_o = boundary_i & ~busy_q & any_req_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q    <= 1'b0;
            ie_q      <= IE_RST;
            ie_save_q <= IE_RST;
        end else if (take_now_o) begin
            busy_q    <= 1'b1;
            ie_save_q <= ie_q;
            ie_q      <= 1'b0;
        end else if (busy_q) begin
            if (iret_i) begin
                busy_q <= 1'b0;
                ie_q   <= ie_save_q;
            end
        end else if (ie_wr_i) begin
            ie_q <= ie_val_i;
        end
    end

    assign busy_o = busy_q;
    assign ie_o   = ie_q;

endmodule

// File: rtl/exc_vector_unit.sv
module exc_vector_unit
    import exc_pkg::*;
#(
    parameter int   PC_W   = 32,
    parameter logic IE_RST = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             boundary_i,
    input  logic [PC_W-1:0]  fault_pc_i,
    input  logic [PC_W-1:0]  seq_pc_i,
    input  logic             jump_taken_i,
    input  logic [PC_W-1:0]  jump_tgt_i,
    input  logic             hw_reset_req_i,
    input  logic             mcheck_i,
    input  logic             init_i,
    input  logic             smi_i,
    input  logic             trap_i,
    input  logic             swi_i,
    input  logic [7:0]       swi_vec_i,
    input  logic             nmi_i,
    input  logic             intr_i,
    input  logic             dtlb_fault_i,
    input  logic             fpe_fault_i,
    input  logic             align_fault_i,
    input  logic             itlb_fault_i,
    input  logic             illop_fault_i,
    input  logic             iret_i,
    input  logic             ie_wr_i,
    input  logic             ie_val_i,
    output logic             take_o,
    output logic             flush_o,
    output logic [7:0]       vector_o,
    output logic [PC_W-1:0]  ret_pc_o,
    output logic             busy_o,
    output logic             ie_o
);

    localparam int IW = $clog2(NCLS);

    logic [NCLS-1:0] raw, eff, req, grant, clr;
    logic [IW-1:0]   sel_idx;
    logic            any_req, take_now, ie_cur;
    exc_cls_e        sel_cls;
    logic [PC_W-1:0] next_pc, pc_sel;
    logic [7:0]      vec_sel;

    always_comb begin
        raw          = '0;
        raw[C_HWRST] = hw_reset_req_i;
        raw[C_MCHK]  = mcheck_i;
        raw[C_INIT]  = init_i;
        raw[C_SMI]   = smi_i;
        raw[C_TRAP]  = trap_i;
        raw[C_SWI]   = swi_i;
        raw[C_NMI]   = nmi_i;
        raw[C_INTR]  = intr_i & ie_cur;
        raw[C_DTLB]  = dtlb_fault_i;
        raw[C_FPE]   = fpe_fault_i;
        raw[C_ALIGN] = align_fault_i;
        raw[C_ITLB]  = itlb_fault_i;
        raw[C_ILLOP] = illop_fault_i;
    end

    exc_pend_latch #(.N(NCLS), .MASK(STICKY_MASK)) u_pend (
        .clk   (clk),
        .rst   (rst),
        .raw_i (raw),
        .clr_i (clr),
        .eff_o (eff)
    );

    assign req = boundary_i ? eff : '0;

    exc_arbiter #(.N(NCLS)) u_arb (
        .req_i   (req),
        .grant_o (grant),
        .idx_o   (sel_idx),
        .any_o   (any_req)
    );

    exc_ctrl #(.IE_RST(IE_RST)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .boundary_i (boundary_i),
        .any_req_i  (any_req),
        .iret_i     (iret_i),
        .ie_wr_i    (ie_wr_i),
        .ie_val_i   (ie_val_i),
        .take_now_o (take_now),
        .busy_o     (busy_o),
        .ie_o       (ie_cur)
    );

    assign ie_o    = ie_cur;
    assign clr     = take_now ? grant : '0;
    assign sel_cls = exc_cls_e'(sel_idx);
    assign next_pc = jump_taken_i ? jump_tgt_i : seq_pc_i;

    always_comb begin
        case (ret_kind(sel_cls))
            RK_FAULT: pc_sel = fault_pc_i;
            RK_NEXT:  pc_sel = next_pc;
            default:  pc_sel = '0;
        endcase
        vec_sel = (sel_cls == C_SWI) ? swi_vec_i : fixed_vec(sel_cls);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            take_o   <= 1'b0;
            flush_o  <= 1'b0;
            vector_o <= '0;
            ret_pc_o <= '0;
        end else begin
            take_o   <= take_now;
            flush_o  <= take_now;
            vector_o <= take_now ? vec_sel : '0;
            ret_pc_o <= take_now ? pc_sel  : '0;
        end
    end

endmodule

// File: rtl/exc_vector_unit_chk.sv
module exc_vector_unit_chk #(
    parameter int PC_W = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            boundary_i,
    input logic            iret_i,
    input logic            swi_i,
    input logic            hw_reset_req_i,
    input logic            take_o,
    input logic            flush_o,
    input logic [7:0]      vector_o,
    input logic [PC_W-1:0] ret_pc_o,
    input logic            busy_o,
    input logic            ie_o
);

    // R2: a take follows an idle boundary edge
    p_take_at_boundary_r2: assert property (@(posedge clk) disable iff (rst)
        take_o |-> ($past(boundary_i) && !$past(busy_o)));

    // R2: the take strobe lasts one cycle
    p_take_single_r2: assert property (@(posedge clk) disable iff (rst)
        take_o |=> !take_o);

    // R7: entering a handler sets busy and drops the enable flag
    p_enter_busy_r7: assert property (@(posedge clk) disable iff (rst)
        take_o |-> (busy_o && !ie_o));

    // R7: busy holds until a return pulse
    p_busy_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !iret_i) |=> busy_o);

    // R10: the enable flag cannot be written while busy
    p_ie_frozen_r10: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> !ie_o);

    // R6: a maskable take needs the enable flag set at sampling
    p_mask_r6: assert property (@(posedge clk) disable iff (rst)
        (take_o && vector_o == 8'h20 && !$past(swi_i)) |-> $past(ie_o));

    // R5: a reset request wins with a zero return PC
    p_abort_pc_r5: assert property (@(posedge clk) disable iff (rst)
        (take_o && $past(hw_reset_req_i)) |-> (vector_o == 8'h01 && ret_pc_o == '0));

    // R11: flush accompanies every take
    p_flush_r11: assert property (@(posedge clk) disable iff (rst)
        flush_o == take_o);

endmodule

bind exc_vector_unit exc_vector_unit_chk #(.PC_W(PC_W)) u_chk (.*);

// File: tb/exc_vector_unit_tb.sv
module exc_vector_unit_tb;

    localparam int PC_W = 32;
    localparam logic [PC_W-1:0] FPC = 32'h0000_1000;
    localparam logic [PC_W-1:0] SPC = 32'h0000_1004;
    localparam logic [PC_W-1:0] TPC = 32'h0000_2000;

    // bench request bit positions (ladder order)
    localparam int B_HW = 0, B_MC = 1, B_INIT = 2, B_SMI = 3, B_TRAP = 4, B_SWI = 5,
                   B_NMI = 6, B_INTR = 7, B_DTLB = 8, B_FPE = 9, B_ALIGN = 10,
                   B_ITLB = 11, B_ILL = 12;

    logic clk = 0, rst = 1;
    logic boundary = 0, jmp = 0, iret = 0, ie_wr = 0, ie_val = 0;
    logic [12:0] rq = '0;
    logic [7:0]  swi_vec = 8'h80;
    logic take, flush, busy, ie;
    logic [7:0] vec;
    logic [PC_W-1:0] rpc;

    int checks = 0, errors = 0;
    bit done = 0;

    logic [7:0]      q_vec[$];
    logic [PC_W-1:0] q_pc[$];
    string           q_tag[$];

    always #4 clk = ~clk;

    exc_vector_unit #(.PC_W(PC_W)) u_dut (
        .clk(clk), .rst(rst), .boundary_i(boundary),
        .fault_pc_i(FPC), .seq_pc_i(SPC), .jump_taken_i(jmp), .jump_tgt_i(TPC),
        .hw_reset_req_i(rq[B_HW]), .mcheck_i(rq[B_MC]), .init_i(rq[B_INIT]),
        .smi_i(rq[B_SMI]), .trap_i(rq[B_TRAP]), .swi_i(rq[B_SWI]), .swi_vec_i(swi_vec),
        .nmi_i(rq[B_NMI]), .intr_i(rq[B_INTR]), .dtlb_fault_i(rq[B_DTLB]),
        .fpe_fault_i(rq[B_FPE]), .align_fault_i(rq[B_ALIGN]), .itlb_fault_i(rq[B_ITLB]),
        .illop_fault_i(rq[B_ILL]), .iret_i(iret), .ie_wr_i(ie_wr), .ie_val_i(ie_val),
        .take_o(take), .flush_o(flush), .vector_o(vec), .ret_pc_o(rpc),
        .busy_o(busy), .ie_o(ie)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops the scoreboard on every take
    always @(negedge clk) begin
        if (!rst && take) begin
            if (q_vec.size() == 0) begin
                check(1'b0, "R2 unexpected take", {24'h0, vec}, 32'h0);
            end else begin
                logic [7:0]      ev;
                logic [PC_W-1:0] ep;
                string           tg;
                ev = q_vec.pop_front();
                ep = q_pc.pop_front();
                tg = q_tag.pop_front();
                check(vec == ev, {tg, " vector"}, {24'h0, vec}, {24'h0, ev});
                check(rpc == ep, {tg, " return PC"}, rpc, ep);
                check(flush == 1'b1, "R11 flush with take", {31'h0, flush}, 32'h1);
            end
        end
    end

    task automatic expect_take(input logic [7:0] v, input logic [PC_W-1:0] p, input string tag);
        q_vec.push_back(v);
        q_pc.push_back(p);
        q_tag.push_back(tag);
    endtask

    task automatic do_iret();
        iret = 1;
        @(negedge clk);
        iret = 0;
    endtask

    // one boundary; optional expected take; optional automatic return
    task automatic bnd(input logic [12:0] r, input logic j, input bit exp,
                       input logic [7:0] v, input logic [PC_W-1:0] p,
                       input string tag, input bit ret);
        @(negedge clk);
        rq = r; jmp = j; boundary = 1;
        if (exp) expect_take(v, p, tag);
        @(negedge clk);
        rq = '0; jmp = 0; boundary = 0;
        @(negedge clk);
        if (exp) check(take == 1'b0, "R2 one-cycle take", {31'h0, take}, 32'h0);
        if (exp && ret) do_iret();
        check(q_vec.size() == 0, {tag, " scoreboard drained"}, q_vec.size(), 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        check(take == 0,  "R1 take_o", {31'h0, take}, 0);
        check(flush == 0, "R1 flush_o", {31'h0, flush}, 0);
        check(busy == 0,  "R1 busy_o", {31'h0, busy}, 0);
        check(ie == 1,    "R1 ie_o", {31'h0, ie}, 1);

        // R3/R4/R5 fault ladder
        bnd(13'(1) << B_ILL, 0, 1, 8'h06, FPC, "R4 illegal opcode", 1);
        bnd((13'(1) << B_ITLB) | (13'(1) << B_ILL), 0, 1, 8'h0F, FPC, "R3 itlb over illop", 1);
        bnd((13'(1) << B_ALIGN) | (13'(1) << B_ITLB), 0, 1, 8'h11, FPC, "R3 align over itlb", 1);
        bnd((13'(1) << B_FPE) | (13'(1) << B_ALIGN), 0, 1, 8'h10, FPC, "R3 fp over align", 1);
        bnd((13'(1) << B_DTLB) | (13'(1) << B_FPE), 0, 1, 8'h0E, FPC, "R3 dtlb over fp", 1);
        bnd((13'(1) << B_INTR) | (13'(1) << B_DTLB), 0, 1, 8'h20, SPC, "R5 intr over dtlb next pc", 1);
        bnd((13'(1) << B_NMI) | (13'(1) << B_INTR), 0, 1, 8'h02, SPC, "R3 nmi over intr", 1);
        // trap beats pending-capable NMI; NMI stays pending (R8)
        bnd((13'(1) << B_TRAP) | (13'(1) << B_NMI), 1, 1, 8'h05, TPC, "R5 trap jump target", 1);
        bnd('0, 0, 1, 8'h02, SPC, "R8 nmi kept pending", 1);
        // software interrupt operand vector
        swi_vec = 8'h80;
        bnd((13'(1) << B_SWI) | (13'(1) << B_INTR), 0, 1, 8'h80, SPC, "R4 swi operand", 1);
        bnd((13'(1) << B_TRAP) | (13'(1) << B_SWI), 0, 1, 8'h05, SPC, "R3 trap over swi", 1);
        bnd('0, 0, 0, 8'h00, '0, "R9 swi not held", 1);
        bnd((13'(1) << B_TRAP) | (13'(1) << B_DTLB), 0, 1, 8'h05, SPC, "R3 trap over dtlb", 1);
        bnd('0, 0, 0, 8'h00, '0, "R9 dtlb not held", 1);
        // system events
        bnd((13'(1) << B_SMI) | (13'(1) << B_TRAP), 0, 1, 8'h04, SPC, "R3 smi over trap", 1);
        bnd((13'(1) << B_INIT) | (13'(1) << B_SMI), 0, 1, 8'h03, SPC, "R3 init over smi", 1);
        bnd('0, 0, 1, 8'h04, SPC, "R8 smi kept pending", 1);
        bnd((13'(1) << B_MC) | (13'(1) << B_INIT), 0, 1, 8'h12, '0, "R5 mcheck zero pc", 1);
        bnd('0, 0, 1, 8'h03, SPC, "R8 init kept pending", 1);
        bnd((13'(1) << B_HW) | (13'(1) << B_MC), 1, 1, 8'h01, '0, "R5 reset zero pc", 1);
        bnd('0, 0, 1, 8'h12, '0, "R8 mcheck kept pending", 1);

        // R2: request without a boundary is not sampled
        @(negedge clk);
        rq = 13'(1) << B_ILL;
        @(negedge clk);
        rq = '0;
        @(negedge clk);
        check(take == 0 && q_vec.size() == 0, "R2 no boundary no take", {31'h0, take}, 0);

        // R10 enable write, R6 masking
        @(negedge clk);
        ie_wr = 1; ie_val = 0;
        @(negedge clk);
        ie_wr = 0;
        check(ie == 0, "R10 ie write", {31'h0, ie}, 0);
        bnd(13'(1) << B_INTR, 0, 0, 8'h00, '0, "R6 intr masked", 1);
        bnd(13'(1) << B_NMI, 0, 1, 8'h02, SPC, "R6 nmi unmaskable", 0);
        check(busy == 1, "R7 busy after take", {31'h0, busy}, 1);
        check(ie == 0,   "R7 ie cleared on take", {31'h0, ie}, 0);
        do_iret();
        check(busy == 0, "R7 busy cleared by iret", {31'h0, busy}, 0);
        check(ie == 0,   "R7 ie restored to 0", {31'h0, ie}, 0);
        swi_vec = 8'h33;
        bnd(13'(1) << B_SWI, 0, 1, 8'h33, SPC, "R6 swi unmaskable", 1);

        // R7/R10 while busy
        bnd(13'(1) << B_DTLB, 0, 1, 8'h0E, FPC, "R7 enter handler", 0);
        ie_wr = 1; ie_val = 1;
        @(negedge clk);
        ie_wr = 0;
        check(ie == 0, "R10 write ignored while busy", {31'h0, ie}, 0);
        // NMI pulse during handler is captured (R8)
        rq = 13'(1) << B_NMI;
        @(negedge clk);
        rq = '0;
        bnd(13'(1) << B_ILL, 0, 0, 8'h00, '0, "R7 boundary ignored while busy", 0);
        check(busy == 1, "R7 still busy", {31'h0, busy}, 1);
        do_iret();
        check(ie == 0, "R7 ie restored not written", {31'h0, ie}, 0);
        bnd('0, 0, 1, 8'h02, SPC, "R8 nmi captured while busy", 1);
        @(negedge clk);
        ie_wr = 1; ie_val = 1;
        @(negedge clk);
        ie_wr = 0;
        check(ie == 1, "R10 ie set", {31'h0, ie}, 1);
        bnd(13'(1) << B_INTR, 1, 1, 8'h20, TPC, "R6 intr enabled jump target", 1);
        check(ie == 1, "R7 ie restored to 1", {31'h0, ie}, 1);

        repeat (4) @(negedge clk);
        check(q_vec.size() == 0, "R2 all expected takes seen", q_vec.size(), 0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule